// File: doc/BRIEF.md
# Fast A20 Gate and System Control Port

This block sits between the CPU and the memory system of a PC-compatible platform and decides whether address bit 20 reaches the bus. Three independent sources can enable that bit: a bit in the system control port at I/O 0x92, a force flag driven purely by the access type on I/O 0xEE, and a request from the external keyboard controller. Their logical OR is the gate. While the gate is closed, bit 20 of the outgoing 32-bit address is held at 0, so each odd megabyte aliases the even megabyte below it.

The same port at 0x92 also holds a disk activity LED field and a password-lock bit that can be set but never cleared. Setting bit 0 of that port requests a fast CPU reset. Any write to I/O 0xEF does the same. A reset request becomes a pulse lasting a configurable number of clock cycles. Firmware uses the block through ordinary single-cycle I/O reads and writes. Read data is combinational, and the side effects of an access take hold at the clock edge that samples it.

Top module: `fast_a20_ctl`

## Requirements
- R1: After reset, port 0x92 reads 0x00, the A20 gate is closed when the keyboard request is low, the LED is off, the lock is clear and no CPU reset is asserted.
- R2: Bit 1 of port 0x92 is a stored enable. A write sets it to the written value, it reads back in bit 1, and it opens the gate when it is 1.
- R3: Writing 1 to bit 0 of port 0x92 asserts `cpu_reset_o` for exactly RST_CYCLES cycles, starting in the cycle after the write. Bit 0 always reads 0.
- R4: Bit 3 of port 0x92 (password lock) is set by writing 1 and is never cleared by a write. It reads back in bit 3 and drives `pw_lock_o`.
- R5: Bits 7:6 of port 0x92 are stored and read back. `disk_led_o` is 1 whenever the field is not 00.
- R6: Bits 2, 4 and 5 of port 0x92 read as 0 whatever was written.
- R7: A read of port 0xEE returns 0xFF and sets the force flag, which opens the A20 gate from the next cycle.
- R8: A write of any value to port 0xEE clears the force flag. If a read and a write of 0xEE happen in the same cycle, the write wins.
- R9: Any write to port 0xEF asserts `cpu_reset_o` for RST_CYCLES cycles, starting in the cycle after the write.
- R10: `a20_o` is the OR of the 0x92 enable, the 0xEE force flag and `kbc_a20_req`. Any one source opens the gate.
- R11: `cpu_addr_o` equals `cpu_addr_i` in every bit except bit 20. Bit 20 is passed through when `a20_o` is 1 and is 0 otherwise.
- R12: Reads of any other I/O address return 0x00, and writes to any other address change no state and cause no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| kbc_a20_req | input | 1 | A20 enable request from keyboard controller |
| cpu_addr_i | input | 32 | Address from CPU |
| cpu_addr_o | output | 32 | Address to memory system, bit 20 gated |
| a20_o | output | 1 | Gate state, 1 = bit 20 propagates |
| cpu_reset_o | output | 1 | Fast CPU reset pulse |
| disk_led_o | output | 1 | Disk activity LED |
| pw_lock_o | output | 1 | Power-on password area locked |

## Verification
The bench builds the block with RST_CYCLES set to 3, so each reset pulse can be counted cycle by cycle inside a short window after every write. With the lock still clear, the bench writes all 128 port values that have bit 3 at 0 and computes the readback, LED, gate and pulse length for each one arithmetically. It then checks the sticky lock, and it checks all eight combinations of the three A20 sources against a set of addresses chosen around bit 20.

// File: rtl/fa20_pkg.sv
package fa20_pkg;
    localparam int IO_AW = 16;

    typedef struct packed {
        logic       a20_en;
        logic       pw_lock;
        logic [1:0] led;
        logic       ee_force;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{a20_en: 1'b0, pw_lock: 1'b0, led: 2'b00, ee_force: 1'b0};
endpackage

// File: rtl/fa20_regs.sv
module fa20_regs
    import fa20_pkg::*;
#(
    parameter logic [IO_AW-1:0] PORT_SYS  = 16'h0092,
    parameter logic [IO_AW-1:0] PORT_GATE = 16'h00EE,
    parameter logic [IO_AW-1:0] PORT_RST  = 16'h00EF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output ctl_t             ctl,
    output logic             rst_req
);
    ctl_t ctl_d, ctl_q;
    logic hit_sys, hit_gate, hit_rst;

    assign hit_sys  = (io_addr == PORT_SYS);
    assign hit_gate = (io_addr == PORT_GATE);
    assign hit_rst  = (io_addr == PORT_RST);

    always_comb begin
        ctl_d   = ctl_q;
        rst_req = 1'b0;
        if (io_rd && hit_gate) begin
            ctl_d.ee_force = 1'b1;
        end
        if (io_wr) begin
            if (hit_gate) begin
                ctl_d.ee_force = 1'b0;
            end
            if (hit_rst) begin
                rst_req = 1'b1;
            end
            if (hit_sys) begin
                ctl_d.a20_en = io_wdata[1];
                ctl_d.led    = io_wdata[7:6];
                if (!ctl_q.pw_lock) begin
                    ctl_d.pw_lock = io_wdata[3];
                end
                rst_req = io_wdata[0];
            end
        end
    end

    always_comb begin
        io_rdata = 8'h00;
        if (hit_sys) begin
            io_rdata = {ctl_q.led, 2'b00, ctl_q.pw_lock, 1'b0, ctl_q.a20_en, 1'b0};
        end else if (hit_gate) begin
            io_rdata = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/fa20_pulse.sv
module fa20_pulse #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/fa20_gate.sv
module fa20_gate #(
    parameter int ADDR_W  = 32,
    parameter int GATE_BIT = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              src_port,
    input  logic              src_force,
    input  logic              src_kbc,
    output logic [ADDR_W-1:0] addr_o,
    output logic              open_o
);
    localparam logic [ADDR_W-1:0] MASK = ~(ADDR_W'(1) << GATE_BIT);

    always_comb begin
        open_o = src_port | src_force | src_kbc;
        addr_o = open_o ? addr_i : (addr_i & MASK);
    end
endmodule

// File: rtl/fast_a20_ctl.sv
module fast_a20_ctl
    import fa20_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              kbc_a20_req,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic [ADDR_W-1:0] cpu_addr_o,
    output logic              a20_o,
    output logic              cpu_reset_o,
    output logic              disk_led_o,
    output logic              pw_lock_o
);
    ctl_t ctl;
    logic rst_req;
    logic ee_force;

    fa20_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .ctl      (ctl),
        .rst_req  (rst_req)
    );

    fa20_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (rst_req),
        .pulse (cpu_reset_o)
    );

    fa20_gate #(.ADDR_W(ADDR_W), .GATE_BIT(20)) u_gate (
        .addr_i    (cpu_addr_i),
        .src_port  (ctl.a20_en),
        .src_force (ctl.ee_force),
        .src_kbc   (kbc_a20_req),
        .addr_o    (cpu_addr_o),
        .open_o    (a20_o)
    );

    assign ee_force   = ctl.ee_force;
    assign disk_led_o = |ctl.led;
    assign pw_lock_o  = ctl.pw_lock;
endmodule

// File: rtl/fast_a20_ctl_chk.sv
module fast_a20_ctl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              kbc_a20_req,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic [ADDR_W-1:0] cpu_addr_o,
    input logic              a20_o,
    input logic              cpu_reset_o,
    input logic              pw_lock_o,
    input logic              ee_force
);
    localparam logic [ADDR_W-1:0] B20 = ADDR_W'(1) << 20;

    a_r11_other_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_o | B20) == (cpu_addr_i | B20));
    a_r11_bit20_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_o |-> (cpu_addr_o & B20) == '0);
    a_r10_kbc_opens: assert property (@(posedge clk) disable iff (!rst_n)
        kbc_a20_req |-> a20_o);
    a_r7_ee_read_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == 16'h00EE) |=> (ee_force && a20_o));
    a_r7_ee_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == 16'h00EE) |-> io_rdata == 8'hFF);
    a_r8_ee_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h00EE) |=> !ee_force);
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pw_lock_o |=> pw_lock_o);
    a_r9_ef_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h00EF) |=> cpu_reset_o);
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == 16'h0092) |-> (io_rdata[5:4] == 2'b00 && io_rdata[2] == 1'b0 && io_rdata[0] == 1'b0));
endmodule

bind fast_a20_ctl fast_a20_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_rdata    (io_rdata),
    .kbc_a20_req (kbc_a20_req),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_addr_o  (cpu_addr_o),
    .a20_o       (a20_o),
    .cpu_reset_o (cpu_reset_o),
    .pw_lock_o   (pw_lock_o),
    .ee_force    (ee_force)
);

// File: tb/fast_a20_ctl_bench.sv
module fast_a20_ctl_bench;
    localparam int NRST = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        kbc_a20_req = 1'b0;
    logic [31:0] cpu_addr_i = '0;
    logic [31:0] cpu_addr_o;
    logic        a20_o, cpu_reset_o, disk_led_o, pw_lock_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fast_a20_ctl #(.ADDR_W(32), .RST_CYCLES(NRST)) u_fast_a20_ctl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .kbc_a20_req(kbc_a20_req),
        .cpu_addr_i(cpu_addr_i), .cpu_addr_o(cpu_addr_o), .a20_o(a20_o),
        .cpu_reset_o(cpu_reset_o), .disk_led_o(disk_led_o), .pw_lock_o(pw_lock_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1 io_wr = 1'b0; io_addr = 16'h0000;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0; io_addr = 16'h0000;
    endtask

    task automatic count_pulse(output int n);
        n = 0;
        for (int i = 0; i < NRST + 3; i++) begin
            @(negedge clk);
            if (cpu_reset_o) n++;
        end
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 a20", {31'b0, a20_o}, 32'd0);
        check("R1 reset", {31'b0, cpu_reset_o}, 32'd0);
        check("R1 led", {31'b0, disk_led_o}, 32'd0);
        check("R1 lock", {31'b0, pw_lock_o}, 32'd0);
        io_read(16'h0092, rd);
        check("R1 port read", {24'b0, rd}, 32'h00);

        // R2 R3 R5 R6 sweep over every value with bit 3 clear
        for (int v = 0; v < 256; v++) begin
            if (v[3] == 1'b0) begin
                io_write(16'h0092, 8'(v));
                count_pulse(n);
                check("R3 pulse length", n, v[0] ? NRST : 0);
                check("R2 gate", {31'b0, a20_o}, {31'b0, v[1]});
                check("R5 led", {31'b0, disk_led_o}, {31'b0, (v[7:6] != 2'b00)});
                io_read(16'h0092, rd);
                check("R6 R3 R2 R5 readback", {24'b0, rd}, 32'(v & 8'hC2));
            end
        end

        // R4 sticky lock
        check("R4 still clear", {31'b0, pw_lock_o}, 32'd0);
        io_write(16'h0092, 8'h08);
        @(negedge clk);
        check("R4 set", {31'b0, pw_lock_o}, 32'd1);
        io_write(16'h0092, 8'h42);
        @(negedge clk);
        check("R4 not cleared", {31'b0, pw_lock_o}, 32'd1);
        io_read(16'h0092, rd);
        check("R4 readback", {24'b0, rd}, 32'h4A);
        io_write(16'h0092, 8'h00);

        // R7 R8 force flag
        @(negedge clk);
        check("R8 gate closed base", {31'b0, a20_o}, 32'd0);
        io_read(16'h00EE, rd);
        check("R7 data", {24'b0, rd}, 32'hFF);
        @(negedge clk);
        check("R7 force opens", {31'b0, a20_o}, 32'd1);
        io_write(16'h00EE, 8'hA5);
        @(negedge clk);
        check("R8 write clears", {31'b0, a20_o}, 32'd0);
        io_read(16'h00EE, rd);
        @(negedge clk);
        io_addr = 16'h00EE; io_rd = 1'b1; io_wr = 1'b1; io_wdata = 8'hFF;
        @(posedge clk);
        #1 io_rd = 1'b0; io_wr = 1'b0; io_addr = 16'h0000;
        @(negedge clk);
        check("R8 write wins", {31'b0, a20_o}, 32'd0);

        // R9 0xEF write
        io_write(16'h00EF, 8'h00);
        count_pulse(n);
        check("R9 pulse length", n, NRST);

        // R12 unmapped
        io_read(16'h0060, rd);
        check("R12 unmapped read", {24'b0, rd}, 32'h00);
        io_write(16'h0093, 8'hFF);
        count_pulse(n);
        check("R12 no reset", n, 0);
        io_read(16'h0092, rd);
        check("R12 no state change", {24'b0, rd}, 32'h08);

        // R10 R11 all source combinations
        for (int s = 0; s < 8; s++) begin
            io_write(16'h0092, s[0] ? 8'h02 : 8'h00);
            if (s[1]) io_read(16'h00EE, rd);
            else io_write(16'h00EE, 8'h00);
            @(negedge clk);
            kbc_a20_req = s[2];
            for (int k = 0; k < 5; k++) begin
                logic [31:0] a;
                case (k)
                    0: a = 32'h0010_0000;
                    1: a = 32'hFFFF_FFFF;
                    2: a = 32'h0012_3456;
                    3: a = 32'h000F_FFF0;
                    default: a = 32'hFFF0_0000;
                endcase
                cpu_addr_i = a;
                #1;
                check("R10 gate OR", {31'b0, a20_o}, {31'b0, (s != 0)});
                check("R11 address", cpu_addr_o, (s != 0) ? a : (a & ~32'h0010_0000));
            end
            kbc_a20_req = 1'b0;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule